// File: doc/BRIEF.md
# Frame Scan DMA Address Sequencer

This block generates the read addresses for one display-refresh DMA channel. Software programs a start address, an end address, an element size, per-frame and per-block counts, and signed strides through a 16-bit register port. Once started, the block presents one element address at a time on a valid/ready interface to the memory side and advances to the next address only when that address is accepted. It does not move any pixel data.

Two scan modes are available. The sequential mode walks upward from the start address one element at a time until it reaches the end address. The double-indexed mode walks a grid of elements and frames with separate signed strides for the step inside a frame and the step between frames, so that rotated or mirrored pictures can be fetched without a copy in memory. All geometry sits in a programmed register set that software may rewrite at any time. A commit bit copies it into the active set that drives the scan. If a block is in flight, the copy waits for the block boundary, so a running refresh can be retargeted without a glitch. An optional repeat loop restarts the scan at the start address after every block. A completion status bit with an interrupt enable reports each finished block.

Top module: `frame_dma_addr_gen`

## Requirements
- R1: After reset every register reads back as zero, `mem_valid` is low and `blk_irq` is low.
- R2: The element size comes from bits 1:0 of the format register (offset 2). Code 0 selects 1 byte, code 1 selects 2 bytes, code 2 selects 4 bytes, and code 3 is treated as 1 byte.
- R3: When the mode field (bits 13:12 of the channel control register, offset 0) is not 3, the scan is sequential. It emits top, top+size, top+2*size and so on. The last address of the block is the first emitted address that is unsigned greater than or equal to the bottom address.
- R4: When the mode field is 3, the scan is double-indexed. Each block has frame_count frames of element_count elements, and a count of 0 acts as 1. Inside a frame, the next address is the current address + size - 1 + the sign-extended 16-bit element index. After the last element of a frame, the 32-bit frame index takes the place of the element index in the same formula.
- R5: An address is consumed only in a cycle with `mem_valid` and `mem_ready` both high. While `mem_valid` is high and `mem_ready` is low, `mem_addr` holds its value.
- R6: A scan starts only when the channel enable (bit 7 of the channel control register) and the request-path enable (bit 8 of the auxiliary control register, offset 1) are both 1. Writing bit 7 to 0 drops `mem_valid` in the next cycle and halts the scan.
- R7: Writing 1 to bit 11 of the channel control register commits the programmed set (top, bottom, counts, indexes, size, mode) into the active set. Bit 11 always reads 0. When a scan is running, the commit is held until that block's last address is accepted, and the current block still uses the old set.
- R8: When both bit 8 and bit 9 of the channel control register are 1, the scan restarts at top after the last address of a block. Otherwise the block clears the channel enable bit and goes idle after one block.
- R9: Bit 3 of the auxiliary control register is set when a block completes and is cleared by writing 1 to it. `blk_irq` is high exactly when that bit and the interrupt enable (bit 1 of the same register) are both 1.
- R10: The register map has 16-bit registers at these offsets: 3/4 top low/high, 5/6 bottom low/high, 7 element count, 8 frame count, 9 element index, 10/11 frame index low/high. Each reads back its programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational on reg_addr) |
| mem_ready | input | 1 | Memory side accepts the current address |
| mem_valid | output | 1 | An element address is offered |
| mem_addr | output | 2*REG_W | Element address |
| blk_irq | output | 1 | Block-complete interrupt |

## Verification
The assertions check the per-cycle rules on every cycle: the address holds while stalled, nothing starts without both enables, the active set is frozen while a block runs, the single-shot mode self-disables, the repeat mode reloads after a block, and the status bit is set. The exact address sequences can only be shown by the bench scenarios. These include the sequential end test against a misaligned bottom, the signed element and frame strides, counts of zero, every size code, and the deferred commit landing on the following block. The bench compares them with a model of its own.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

   localparam int FDMA_AW = 4;

   typedef enum logic [3:0] {
      OFS_CHAN_CTL  = 4'd0,
      OFS_AUX_CTL   = 4'd1,
      OFS_FORMAT    = 4'd2,
      OFS_TOP_LO    = 4'd3,
      OFS_TOP_HI    = 4'd4,
      OFS_BOT_LO    = 4'd5,
      OFS_BOT_HI    = 4'd6,
      OFS_ELEM_CNT  = 4'd7,
      OFS_FRAME_CNT = 4'd8,
      OFS_ELEM_IDX  = 4'd9,
      OFS_FIDX_LO   = 4'd10,
      OFS_FIDX_HI   = 4'd11
   } fdma_ofs_e;

   // channel control bit positions
   localparam int CC_EN_BIT       = 7;
   localparam int CC_AUTOINIT_BIT = 8;
   localparam int CC_REPEAT_BIT   = 9;
   localparam int CC_COMMIT_BIT   = 11;
   localparam int CC_MODE_LSB     = 12;

   // auxiliary control bit positions
   localparam int AX_IRQEN_BIT  = 1;
   localparam int AX_DONE_BIT   = 3;
   localparam int AX_EXTREQ_BIT = 8;

   localparam logic [1:0] MODE_DOUBLE_IDX = 2'b11;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LOAD = 2'd1,
      SQ_RUN  = 2'd2
   } fdma_state_e;

   function automatic logic [2:0] elem_bytes(input logic [1:0] code);
      case (code)
         2'd1:    elem_bytes = 3'd2;
         2'd2:    elem_bytes = 3'd4;
         default: elem_bytes = 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
   import fdma_pkg::*;
#(
   parameter  int REG_W  = 16,
   localparam int ADDR_W = 2 * REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [FDMA_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               busy,
   input  logic               blk_end,
   output logic               ch_en,
   output logic               ext_en,
   output logic               rpt_on,
   output logic               irq_en,
   output logic               done,
   output logic               blk_irq,
   output logic [ADDR_W-1:0]  act_top,
   output logic [ADDR_W-1:0]  act_bot,
   output logic [ADDR_W-1:0]  act_fidx,
   output logic [REG_W-1:0]   act_ecnt,
   output logic [REG_W-1:0]   act_fcnt,
   output logic [REG_W-1:0]   act_eidx,
   output logic [1:0]         act_dtype,
   output logic [1:0]         act_mode
);

   logic              cc_ai, cc_rpt, pend;
   logic [1:0]        p_mode, p_dtype;
   logic [ADDR_W-1:0] p_top, p_bot, p_fidx;
   logic [REG_W-1:0]  p_ecnt, p_fcnt, p_eidx;
   logic              wr_cc, wr_aux, ep_wr, commit;

   assign wr_cc  = reg_we && (reg_addr == OFS_CHAN_CTL);
   assign wr_aux = reg_we && (reg_addr == OFS_AUX_CTL);
   assign ep_wr  = wr_cc && reg_wdata[CC_COMMIT_BIT];
   // a held commit lands when the channel is idle or the block just closed
   assign commit = pend && (!busy || blk_end);

   assign rpt_on  = cc_ai && cc_rpt;
   assign blk_irq = done && irq_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_en   <= 1'b0;
         cc_ai   <= 1'b0;
         cc_rpt  <= 1'b0;
         ext_en  <= 1'b0;
         irq_en  <= 1'b0;
         done    <= 1'b0;
         pend    <= 1'b0;
         p_mode  <= '0;
         p_dtype <= '0;
         p_top   <= '0;
         p_bot   <= '0;
         p_fidx  <= '0;
         p_ecnt  <= '0;
         p_fcnt  <= '0;
         p_eidx  <= '0;
      end else begin
         if (reg_we) begin
            case (fdma_ofs_e'(reg_addr))
               OFS_CHAN_CTL: begin
                  ch_en  <= reg_wdata[CC_EN_BIT];
                  cc_ai  <= reg_wdata[CC_AUTOINIT_BIT];
                  cc_rpt <= reg_wdata[CC_REPEAT_BIT];
                  p_mode <= reg_wdata[CC_MODE_LSB +: 2];
               end
               OFS_AUX_CTL: begin
                  irq_en <= reg_wdata[AX_IRQEN_BIT];
                  ext_en <= reg_wdata[AX_EXTREQ_BIT];
               end
               OFS_FORMAT:    p_dtype <= reg_wdata[1:0];
               OFS_TOP_LO:    p_top[REG_W-1:0] <= reg_wdata;
               OFS_TOP_HI:    p_top[ADDR_W-1:REG_W] <= reg_wdata;
               OFS_BOT_LO:    p_bot[REG_W-1:0] <= reg_wdata;
               OFS_BOT_HI:    p_bot[ADDR_W-1:REG_W] <= reg_wdata;
               OFS_ELEM_CNT:  p_ecnt <= reg_wdata;
               OFS_FRAME_CNT: p_fcnt <= reg_wdata;
               OFS_ELEM_IDX:  p_eidx <= reg_wdata;
               OFS_FIDX_LO:   p_fidx[REG_W-1:0] <= reg_wdata;
               OFS_FIDX_HI:   p_fidx[ADDR_W-1:REG_W] <= reg_wdata;
               default: ;
            endcase
         end
         if (blk_end && !rpt_on) ch_en <= 1'b0;
         if (blk_end) done <= 1'b1;
         else if (wr_aux && reg_wdata[AX_DONE_BIT]) done <= 1'b0;
         if (ep_wr) pend <= 1'b1;
         else if (commit) pend <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_top   <= '0;
         act_bot   <= '0;
         act_fidx  <= '0;
         act_ecnt  <= '0;
         act_fcnt  <= '0;
         act_eidx  <= '0;
         act_dtype <= '0;
         act_mode  <= '0;
      end else if (commit) begin
         act_top   <= p_top;
         act_bot   <= p_bot;
         act_fidx  <= p_fidx;
         act_ecnt  <= p_ecnt;
         act_fcnt  <= p_fcnt;
         act_eidx  <= p_eidx;
         act_dtype <= p_dtype;
         act_mode  <= p_mode;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (fdma_ofs_e'(reg_addr))
         OFS_CHAN_CTL: begin
            reg_rdata[CC_EN_BIT]          = ch_en;
            reg_rdata[CC_AUTOINIT_BIT]    = cc_ai;
            reg_rdata[CC_REPEAT_BIT]      = cc_rpt;
            reg_rdata[CC_MODE_LSB +: 2]   = p_mode;
         end
         OFS_AUX_CTL: begin
            reg_rdata[AX_IRQEN_BIT]  = irq_en;
            reg_rdata[AX_DONE_BIT]   = done;
            reg_rdata[AX_EXTREQ_BIT] = ext_en;
         end
         OFS_FORMAT:    reg_rdata[1:0] = p_dtype;
         OFS_TOP_LO:    reg_rdata = p_top[REG_W-1:0];
         OFS_TOP_HI:    reg_rdata = p_top[ADDR_W-1:REG_W];
         OFS_BOT_LO:    reg_rdata = p_bot[REG_W-1:0];
         OFS_BOT_HI:    reg_rdata = p_bot[ADDR_W-1:REG_W];
         OFS_ELEM_CNT:  reg_rdata = p_ecnt;
         OFS_FRAME_CNT: reg_rdata = p_fcnt;
         OFS_ELEM_IDX:  reg_rdata = p_eidx;
         OFS_FIDX_LO:   reg_rdata = p_fidx[REG_W-1:0];
         OFS_FIDX_HI:   reg_rdata = p_fidx[ADDR_W-1:REG_W];
         default:       reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/fdma_seq.sv
module fdma_seq
   import fdma_pkg::*;
#(
   parameter  int REG_W  = 16,
   localparam int ADDR_W = 2 * REG_W,
   localparam int CNT_XW = REG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ch_en,
   input  logic              ext_en,
   input  logic              rpt_on,
   input  logic [ADDR_W-1:0] act_top,
   input  logic [ADDR_W-1:0] act_bot,
   input  logic [ADDR_W-1:0] act_fidx,
   input  logic [REG_W-1:0]  act_ecnt,
   input  logic [REG_W-1:0]  act_fcnt,
   input  logic [REG_W-1:0]  act_eidx,
   input  logic [1:0]        act_dtype,
   input  logic [1:0]        act_mode,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              busy,
   output logic              blk_end
);

   fdma_state_e       state;
   logic [ADDR_W-1:0] addr, es, idx_sel, step_di, step_sq;
   logic [REG_W-1:0]  ectr, fctr;
   logic              di_mode, last_elem, last_frame, last_addr, hs;

   assign es       = ADDR_W'(elem_bytes(act_dtype));
   assign di_mode  = (act_mode == MODE_DOUBLE_IDX);

   // a zero count behaves as one because the test is "next >= count"
   assign last_elem  = (CNT_XW'(ectr) + CNT_XW'(1)) >= CNT_XW'(act_ecnt);
   assign last_frame = (CNT_XW'(fctr) + CNT_XW'(1)) >= CNT_XW'(act_fcnt);

   assign idx_sel = last_elem ? act_fidx
                              : {{(ADDR_W-REG_W){act_eidx[REG_W-1]}}, act_eidx};
   assign step_di = addr + es + idx_sel - ADDR_W'(1);
   assign step_sq = addr + es;

   assign last_addr = di_mode ? (last_elem && last_frame) : (addr >= act_bot);

   assign mem_valid = (state == SQ_RUN) && ch_en;
   assign mem_addr  = addr;
   assign busy      = (state != SQ_IDLE);
   assign hs        = mem_valid && mem_ready;
   assign blk_end   = hs && last_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         addr  <= '0;
         ectr  <= '0;
         fctr  <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (ch_en && ext_en) state <= SQ_LOAD;
            SQ_LOAD: begin
               if (!ch_en) state <= SQ_IDLE;
               else begin
                  addr  <= act_top;
                  ectr  <= '0;
                  fctr  <= '0;
                  state <= SQ_RUN;
               end
            end
            SQ_RUN: begin
               if (!ch_en) state <= SQ_IDLE;
               else if (mem_ready) begin
                  if (last_addr) begin
                     state <= rpt_on ? SQ_LOAD : SQ_IDLE;
                  end else if (di_mode) begin
                     addr <= step_di;
                     if (last_elem) begin
                        ectr <= '0;
                        fctr <= fctr + REG_W'(1);
                     end else begin
                        ectr <= ectr + REG_W'(1);
                     end
                  end else begin
                     addr <= step_sq;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/frame_dma_addr_gen.sv
module frame_dma_addr_gen
   import fdma_pkg::*;
#(
   parameter  int REG_W  = 16,
   localparam int ADDR_W = 2 * REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [FDMA_AW-1:0] reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic               mem_ready,
   output logic               mem_valid,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               blk_irq
);

   generate
      if (REG_W < CC_MODE_LSB + 2) begin : g_bad_reg_w
         $error("REG_W must hold the mode field of the channel control register");
      end
   endgenerate

   logic              ch_en, ext_en, rpt_on, irq_en, done, busy, blk_end;
   logic [ADDR_W-1:0] act_top, act_bot, act_fidx;
   logic [REG_W-1:0]  act_ecnt, act_fcnt, act_eidx;
   logic [1:0]        act_dtype, act_mode;

   fdma_regs #(.REG_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy),
      .blk_end   (blk_end),
      .ch_en     (ch_en),
      .ext_en    (ext_en),
      .rpt_on    (rpt_on),
      .irq_en    (irq_en),
      .done      (done),
      .blk_irq   (blk_irq),
      .act_top   (act_top),
      .act_bot   (act_bot),
      .act_fidx  (act_fidx),
      .act_ecnt  (act_ecnt),
      .act_fcnt  (act_fcnt),
      .act_eidx  (act_eidx),
      .act_dtype (act_dtype),
      .act_mode  (act_mode)
   );

   fdma_seq #(.REG_W(REG_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_en     (ch_en),
      .ext_en    (ext_en),
      .rpt_on    (rpt_on),
      .act_top   (act_top),
      .act_bot   (act_bot),
      .act_fidx  (act_fidx),
      .act_ecnt  (act_ecnt),
      .act_fcnt  (act_fcnt),
      .act_eidx  (act_eidx),
      .act_dtype (act_dtype),
      .act_mode  (act_mode),
      .mem_ready (mem_ready),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .busy      (busy),
      .blk_end   (blk_end)
   );

endmodule

// File: rtl/fdma_checker.sv
module fdma_checker #(
   parameter  int REG_W  = 16,
   localparam int ADDR_W = 2 * REG_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              ch_en,
   input logic              ext_en,
   input logic              busy,
   input logic              blk_end,
   input logic              rpt_on,
   input logic [ADDR_W-1:0] act_top,
   input logic              done,
   input logic              blk_irq
);

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_idle_R1: assert (!mem_valid && !blk_irq)
            else $error("reset: outputs not idle");
      end
   end

   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && $past(mem_valid && !mem_ready) |-> $stable(mem_addr))
      else $error("address moved during stall");

   assert_offer_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !blk_end |=> mem_valid || !ch_en)
      else $error("offer withdrawn inside a block");

   assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !(ch_en && ext_en) |=> !busy)
      else $error("scan started without both enables");

   assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !blk_end |=> $stable(act_top))
      else $error("active set changed inside a block");

   assert_single_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      blk_end && !rpt_on |=> !ch_en && !busy)
      else $error("single block did not self-disable");

   assert_repeat_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      blk_end && rpt_on |=> busy && !mem_valid)
      else $error("repeat did not reload");

   assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      blk_end |=> done)
      else $error("status not set at block end");

endmodule

bind frame_dma_addr_gen fdma_checker #(.REG_W(REG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .ch_en     (ch_en),
   .ext_en    (ext_en),
   .busy      (busy),
   .blk_end   (blk_end),
   .rpt_on    (rpt_on),
   .act_top   (act_top),
   .done      (done),
   .blk_irq   (blk_irq)
);

// File: tb/frame_dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module frame_dma_addr_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mem_ready = 1'b0;
   logic        mem_valid;
   logic [31:0] mem_addr;
   logic        blk_irq;

   int n_tests = 0;
   int n_fail  = 0;

   logic [31:0] exp_q [0:127];
   logic [31:0] exp_a [0:127];
   logic [31:0] got_q [0:127];
   int          exp_n;
   int          exp_an;

   always #2 clk = ~clk;

   frame_dma_addr_gen #(.REG_W(16)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .mem_ready (mem_ready),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .blk_irq   (blk_irq)
   );

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic int es_of(input logic [1:0] dt);
      if (dt == 2'd1) return 2;
      if (dt == 2'd2) return 4;
      return 1;
   endfunction

   // expected scan built from the requirements
   function automatic void build_exp(input logic [31:0] top, input logic [31:0] bot,
                                     input logic [1:0] dt, input bit di,
                                     input int ecnt, input int fcnt,
                                     input logic [15:0] eidx, input logic [31:0] fidx);
      logic [31:0] a;
      int es;
      int ec;
      int fc;
      bit stop;
      a = top;
      es = es_of(dt);
      ec = (ecnt == 0) ? 1 : ecnt;
      fc = (fcnt == 0) ? 1 : fcnt;
      exp_n = 0;
      stop = 1'b0;
      if (!di) begin
         while (!stop && exp_n < 64) begin
            exp_q[exp_n] = a;
            exp_n = exp_n + 1;
            if (a >= bot) stop = 1'b1;
            else a = a + 32'(es);
         end
      end else begin
         for (int f = 0; f < fc; f++) begin
            for (int e = 0; e < ec; e++) begin
               exp_q[exp_n] = a;
               exp_n = exp_n + 1;
               if (e == ec - 1)
                  a = a + 32'(es) - 32'd1 + fidx;
               else
                  a = a + 32'(es) - 32'd1 + {{16{eidx[15]}}, eidx};
            end
         end
      end
   endfunction

   task automatic prog(input logic [31:0] top, input logic [31:0] bot, input logic [1:0] dt,
                       input int ecnt, input int fcnt, input logic [15:0] eidx,
                       input logic [31:0] fidx);
      wr(4'd3, top[15:0]);
      wr(4'd4, top[31:16]);
      wr(4'd5, bot[15:0]);
      wr(4'd6, bot[31:16]);
      wr(4'd2, {14'd0, dt});
      wr(4'd7, 16'(ecnt));
      wr(4'd8, 16'(fcnt));
      wr(4'd9, eidx);
      wr(4'd10, fidx[15:0]);
      wr(4'd11, fidx[31:16]);
   endtask

   // gather n accepted addresses into got_q[base..], random ready, stall check
   task automatic collect(input int base, input int n);
      int          got_n;
      int          guard;
      bit          stall;
      logic [31:0] held;
      got_n = 0;
      guard = 0;
      stall = 1'b0;
      held  = '0;
      while (got_n < n && guard < 4000) begin
         @(negedge clk);
         if (stall && mem_valid)
            chk(mem_addr == held, "R5 address held while ready low", mem_addr, held);
         mem_ready = (($urandom % 4) != 0);
         #1;
         if (mem_valid && mem_ready) begin
            got_q[base + got_n] = mem_addr;
            got_n = got_n + 1;
         end
         stall = mem_valid && !mem_ready;
         held  = mem_addr;
         guard = guard + 1;
      end
      @(negedge clk);
      mem_ready = 1'b0;
      if (got_n < n) chk(1'b0, "R5 collect timeout", 32'(got_n), 32'(n));
   endtask

   task automatic run_case(input string tag, input logic [31:0] top, input logic [31:0] bot,
                           input logic [1:0] dt, input logic [1:0] md, input int ecnt,
                           input int fcnt, input logic [15:0] eidx, input logic [31:0] fidx,
                           input bit irqen);
      logic [15:0] v;
      prog(top, bot, dt, ecnt, fcnt, eidx, fidx);
      wr(4'd0, {2'b00, md, 1'b1, 11'd0});
      build_exp(top, bot, dt, md == 2'b11, ecnt, fcnt, eidx, fidx);
      wr(4'd1, 16'h0100 | (irqen ? 16'h0002 : 16'h0000));
      wr(4'd0, {2'b00, md, 4'h0, 8'h80});
      collect(0, exp_n);
      for (int i = 0; i < exp_n; i++)
         chk(got_q[i] == exp_q[i], tag, got_q[i], exp_q[i]);
      repeat (4) @(negedge clk);
      rd(4'd0, v);
      chk(v[7] == 1'b0, "R8 single block clears enable", 32'(v), 32'(v & 16'hFF7F));
      chk(mem_valid == 1'b0, "R8 idle after single block", 32'(mem_valid), 32'd0);
      rd(4'd1, v);
      chk(v[3] == 1'b1, "R9 status set at block end", 32'(v[3]), 32'd1);
      chk(blk_irq == irqen, "R9 irq follows enable", 32'(blk_irq), 32'(irqen));
      wr(4'd1, 16'h0108 | (irqen ? 16'h0002 : 16'h0000));
      rd(4'd1, v);
      chk(v[3] == 1'b0 && blk_irq == 1'b0, "R9 write-one clears status", 32'(v[3]), 32'd0);
   endtask

   initial begin
      #(4 * 150000);
      chk(1'b0, "watchdog expired", 32'd0, 32'd1);
      report();
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [31:0] h;
      logic [31:0] top;
      logic [31:0] fidx;
      logic [15:0] eidx;
      logic [1:0]  dt;
      int          seed;
      seed = $urandom(32'd2024);

      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 12; a++) begin
         rd(4'(a), v);
         chk(v == 16'd0, "R1 register zero after reset", 32'(v), 32'd0);
      end
      chk(!mem_valid && !blk_irq, "R1 outputs idle after reset", {30'd0, mem_valid, blk_irq}, 32'd0);

      // R10 readback
      prog(32'hABCD_1234, 32'h5A5A_0F0F, 2'd2, 3, 5, 16'hFFF8, 32'h8001_0042);
      rd(4'd3, v);  chk(v == 16'h1234, "R10 top low", 32'(v), 32'h1234);
      rd(4'd4, v);  chk(v == 16'hABCD, "R10 top high", 32'(v), 32'hABCD);
      rd(4'd6, v);  chk(v == 16'h5A5A, "R10 bottom high", 32'(v), 32'h5A5A);
      rd(4'd9, v);  chk(v == 16'hFFF8, "R10 element index", 32'(v), 32'hFFF8);
      rd(4'd11, v); chk(v == 16'h8001, "R10 frame index high", 32'(v), 32'h8001);
      wr(4'd0, 16'h3800);
      rd(4'd0, v);  chk(v == 16'h3000, "R7 commit bit reads zero, mode kept", 32'(v), 32'h3000);

      // R6 request-path gate
      prog(32'h0000_0200, 32'h0000_0203, 2'd0, 0, 0, 16'd0, 32'd0);
      wr(4'd0, 16'h0800);
      build_exp(32'h200, 32'h203, 2'd0, 1'b0, 0, 0, 16'd0, 32'd0);
      wr(4'd1, 16'h0002);
      wr(4'd0, 16'h0080);
      repeat (10) @(negedge clk);
      chk(mem_valid == 1'b0, "R6 no start without request-path enable", 32'(mem_valid), 32'd0);
      wr(4'd1, 16'h0102);
      collect(0, exp_n);
      for (int i = 0; i < exp_n; i++)
         chk(got_q[i] == exp_q[i], "R6 start once both enables set", got_q[i], exp_q[i]);
      repeat (3) @(negedge clk);
      wr(4'd1, 16'h010A);

      // directed sequential cases: R3 and R2
      run_case("R3 R2 sequential 1-byte", 32'h100, 32'h107, 2'd0, 2'd0, 0, 0, 16'd0, 32'd0, 1'b1);
      run_case("R3 R2 sequential 2-byte", 32'h1000, 32'h100A, 2'd1, 2'd1, 0, 0, 16'd0, 32'd0, 1'b1);
      run_case("R3 R2 sequential 4-byte misaligned bottom", 32'h20, 32'h2D, 2'd2, 2'd2, 0, 0, 16'd0, 32'd0, 1'b0);
      run_case("R2 code 3 as one byte", 32'h40, 32'h44, 2'd3, 2'd0, 0, 0, 16'd0, 32'd0, 1'b1);
      run_case("R3 top above bottom gives one address", 32'h900, 32'h100, 2'd1, 2'd0, 0, 0, 16'd0, 32'd0, 1'b1);

      // directed double-indexed cases: R4
      run_case("R4 rotated walk negative element index", 32'h8000, 32'h0, 2'd1, 2'd3, 3, 2, 16'hFFF9, 32'h0000_0020, 1'b1);
      run_case("R4 zero counts act as one", 32'h7770, 32'h0, 2'd2, 2'd3, 0, 0, 16'h0010, 32'h0000_0100, 1'b1);
      run_case("R4 negative frame index", 32'h9000, 32'h0, 2'd0, 2'd3, 2, 3, 16'h0003, 32'hFFFF_FFF0, 1'b0);

      // random mix
      for (int k = 0; k < 8; k++) begin
         top  = $urandom & 32'h00FF_FFF0;
         dt   = 2'($urandom % 4);
         eidx = 16'(($urandom % 16)) - 16'd8;
         fidx = 32'(($urandom % 64)) - 32'd32;
         if (k % 2 == 0)
            run_case("R4 random double-indexed", top, 32'h0, dt, 2'd3,
                     1 + int'($urandom % 4), 1 + int'($urandom % 4), eidx, fidx, 1'b1);
         else
            run_case("R3 random sequential", top, top + ($urandom % 40), dt, 2'(k % 3),
                     0, 0, eidx, fidx, 1'b1);
      end

      // R8 repeat and R7 deferred commit
      prog(32'h0000_4000, 32'h0, 2'd1, 3, 2, 16'hFFFE, 32'h0000_0040);
      wr(4'd0, 16'h3800);
      build_exp(32'h4000, 32'h0, 2'd1, 1'b1, 3, 2, 16'hFFFE, 32'h40);
      for (int i = 0; i < exp_n; i++) exp_a[i] = exp_q[i];
      exp_an = exp_n;
      wr(4'd1, 16'h0102);
      wr(4'd0, 16'h3380);
      collect(0, exp_an + 2);
      for (int i = 0; i < exp_an + 2; i++)
         chk(got_q[i] == exp_a[i % exp_an], "R8 repeat restarts at top", got_q[i], exp_a[i % exp_an]);
      h = mem_addr;
      wr(4'd3, 16'h6000);
      wr(4'd4, 16'h0001);
      wr(4'd0, 16'h3B80);
      repeat (3) @(negedge clk);
      chk(mem_valid && mem_addr == h, "R5 R7 stalled offer unchanged by reprogramming", mem_addr, h);
      build_exp(32'h0001_6000, 32'h0, 2'd1, 1'b1, 3, 2, 16'hFFFE, 32'h40);
      collect(exp_an + 2, (exp_an - 2) + exp_n);
      for (int i = 2; i < exp_an; i++)
         chk(got_q[exp_an + i] == exp_a[i], "R7 current block keeps old set",
             got_q[exp_an + i], exp_a[i]);
      for (int i = 0; i < exp_n; i++)
         chk(got_q[2 * exp_an + i] == exp_q[i], "R7 next block uses committed set",
             got_q[2 * exp_an + i], exp_q[i]);
      rd(4'd0, v);
      chk(v[7] == 1'b1, "R8 repeat keeps enable", 32'(v[7]), 32'd1);

      // R6 stop by clearing enable
      wr(4'd0, 16'h3300);
      chk(mem_valid == 1'b0, "R6 enable clear drops valid", 32'(mem_valid), 32'd0);
      repeat (5) @(negedge clk);
      chk(mem_valid == 1'b0, "R6 stays halted", 32'(mem_valid), 32'd0);

      report();
      $finish;
   end

endmodule